// File: doc/BRIEF.md
# Two-Dimensional Strided Address Generator

This block walks a rectangular region of memory and presents one element address at a time to a consumer, such as a bus master or a memory-copy engine. A transfer is a number of rows, each holding a fixed number of elements. Inside a row, each accepted element moves the address forward by the element step. At the last element of a row, the row step is used instead, so the next row can begin anywhere relative to the end of the previous one. Steps are signed. This lets a packed source image and a wider frame buffer both be walked with the same logic. To place an image inside a frame, the destination row step is the skipped bytes plus one element size. A packed source uses just the element size as its row step.

The configuration is captured when the enable input rises from the idle state, and it is frozen while the transfer runs. There are two modes. In single-shot mode the block raises a sticky completion flag after the final element and stays quiet until it is re-enabled. In autobuffer mode it reloads its starting point and repeats without pause, which suits a continuous display refresh. For example, a 480x272 frame of 24-bit pixels fetched as 32-bit elements is 360 elements per row with a 4-byte step. An optional placement mode computes the starting address from a base, a pixel column (forced even) and a row of a fixed-size frame.

Top module: `adgen_2d`

## Requirements
- R1: After reset, `valid`, `run`, `done`, `err`, `row_end` and `xfer_end` are low and `addr` is 0.
- R2: The transfer starts when `enable` is high while the block is idle and the configuration is legal. At the next clock edge `run` and `valid` rise and `addr` equals the start address.
- R3: An element is accepted when `accept` is high while `valid` is high. An accepted element that is not last in its row advances `addr` by the signed element step. While `accept` is low, `addr` holds.
- R4: `row_end` is high while the presented element is the last of its row. Accepting it advances `addr` by the signed row step, restarts the element count and decrements the row count.
- R5: In single-shot mode (`cfg_auto`=0), accepting the final element of the final row drops `run` and `valid` at the next edge and sets `done`. `valid` then stays low for as long as `enable` stays high, and only falls-then-rises of `enable` start a new transfer.
- R6: In autobuffer mode (`cfg_auto`=1), accepting the final element returns `addr` to the start address with `run` still high, and `done` is not set.
- R7: `done` and `err` are sticky. A one-cycle high pulse on `done_clr` or `err_clr` clears the matching flag. If a set and a clear happen in the same cycle, the set wins.
- R8: Configuration inputs changed while `run` is high have no effect on the running transfer. They take effect at the next start.
- R9: A start request is refused with `err` set and `run` left low in two cases. The first is an element or row count of 0. The second is a start address that is misaligned for the element size: bit 0 must be 0 for 16-bit elements (`cfg_wide`=0), and bits 1:0 must be 0 for 32-bit elements (`cfg_wide`=1).
- R10: With `cfg_origin`=1, the start address is `cfg_base` + (`cfg_col` with bit 0 cleared) × PIX_BYTES + `cfg_row` × FRAME_W × PIX_BYTES. With `cfg_origin`=0, it is `cfg_base`.
- R11: Dropping `enable` during a transfer lowers `run` and `valid` at the next edge without setting `done`.
- R12: `xfer_end` is high only while the presented element is the last element of the last row, which implies `row_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Start/keep a transfer; low returns to idle |
| cfg_auto | input | 1 | 1 = autobuffer repeat |
| cfg_wide | input | 1 | Element size: 0 = 16-bit, 1 = 32-bit |
| cfg_origin | input | 1 | 1 = compute start from column and row |
| cfg_base | input | AW | Start address or frame base |
| cfg_col | input | POSW | Pixel column for placement mode |
| cfg_row | input | POSW | Pixel row for placement mode |
| cfg_x_count | input | CW | Elements per row |
| cfg_x_step | input | SW | Signed byte step inside a row |
| cfg_y_count | input | CW | Number of rows |
| cfg_y_step | input | SW | Signed byte step after the last element of a row |
| accept | input | 1 | Consumer takes the presented element |
| done_clr | input | 1 | Clear pulse for `done` |
| err_clr | input | 1 | Clear pulse for `err` |
| addr | output | AW | Current element address |
| valid | output | 1 | `addr` is a live element |
| row_end | output | 1 | Presented element ends its row |
| xfer_end | output | 1 | Presented element ends the transfer |
| run | output | 1 | Transfer in progress |
| done | output | 1 | Sticky single-shot completion |
| err | output | 1 | Sticky illegal-configuration flag |

## Verification
The hardest situation to reach is a configuration change that lands in the middle of a running transfer, followed by a restart that must pick up the new values. The stimulus starts a transfer and alters the base and steps after the first element. It checks that the next addresses still follow the old steps, then drops and raises `enable` and expects the new base. The stimulus also holds `enable` high after completion to show that no second transfer starts by itself. It runs an autobuffer transfer across its wrap point, and it uses negative steps to exercise address wrap-around arithmetic.

// File: rtl/adgen_pkg.sv
package adgen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } adgen_state_e;
endpackage

// File: rtl/adgen_origin.sv
// Start-address formation and legality check for a transfer.
module adgen_origin #(
  parameter int AW        = 32,
  parameter int CW        = 16,
  parameter int POSW      = 10,
  parameter int FRAME_W   = 480,
  parameter int PIX_BYTES = 3
) (
  input  logic            cfg_origin,
  input  logic            cfg_wide,
  input  logic [AW-1:0]   cfg_base,
  input  logic [POSW-1:0] cfg_col,
  input  logic [POSW-1:0] cfg_row,
  input  logic [CW-1:0]   cfg_x_count,
  input  logic [CW-1:0]   cfg_y_count,
  output logic [AW-1:0]   start_addr,
  output logic            cfg_ok
);
  localparam int LINE_BYTES = FRAME_W * PIX_BYTES;

  logic [POSW-1:0] col_even;
  logic [AW-1:0]   placed;
  logic            aligned;

  always_comb begin
    col_even   = {cfg_col[POSW-1:1], 1'b0};
    placed     = cfg_base + AW'(col_even) * AW'(PIX_BYTES)
                          + AW'(cfg_row) * AW'(LINE_BYTES);
    start_addr = cfg_origin ? placed : cfg_base;
    aligned    = cfg_wide ? (start_addr[1:0] == 2'b00) : !start_addr[0];
    cfg_ok     = aligned && (cfg_x_count != '0) && (cfg_y_count != '0);
  end
endmodule

// File: rtl/adgen_walk.sv
// Address and row/element counters with frozen configuration copy.
module adgen_walk #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic          cfg_auto,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] cfg_x_count,
  input  logic [SW-1:0] cfg_x_step,
  input  logic [CW-1:0] cfg_y_count,
  input  logic [SW-1:0] cfg_y_step,
  output logic [AW-1:0] addr,
  output logic          last_x,
  output logic          last_y,
  output logic          auto_q
);
  localparam int EXT = AW - SW;

  logic [AW-1:0] addr_q, addr_d, start_q;
  logic [CW-1:0] xcnt_q, xcnt_d, ycnt_q, ycnt_d, xinit_q, yinit_q;
  logic [SW-1:0] xstep_q, ystep_q;
  logic [AW-1:0] xstep_ext, ystep_ext;
  logic          walk_en;

  always_comb begin
    xstep_ext = {{EXT{xstep_q[SW-1]}}, xstep_q};
    ystep_ext = {{EXT{ystep_q[SW-1]}}, ystep_q};
    last_x    = (xcnt_q == CW'(1));
    last_y    = (ycnt_q == CW'(1));
    walk_en   = load | adv;
    addr_d    = addr_q;
    xcnt_d    = xcnt_q;
    ycnt_d    = ycnt_q;
    if (load) begin
      addr_d = start_addr;
      xcnt_d = cfg_x_count;
      ycnt_d = cfg_y_count;
    end else if (adv) begin
      if (!last_x) begin
        addr_d = addr_q + xstep_ext;
        xcnt_d = xcnt_q - CW'(1);
      end else if (!last_y) begin
        addr_d = addr_q + ystep_ext;
        xcnt_d = xinit_q;
        ycnt_d = ycnt_q - CW'(1);
      end else begin
        addr_d = start_q;
        xcnt_d = xinit_q;
        ycnt_d = yinit_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      xcnt_q <= '0;
      ycnt_q <= '0;
    end else if (walk_en) begin
      addr_q <= addr_d;
      xcnt_q <= xcnt_d;
      ycnt_q <= ycnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      xinit_q <= '0;
      yinit_q <= '0;
      xstep_q <= '0;
      ystep_q <= '0;
      auto_q  <= 1'b0;
    end else if (load) begin
      start_q <= start_addr;
      xinit_q <= cfg_x_count;
      yinit_q <= cfg_y_count;
      xstep_q <= cfg_x_step;
      ystep_q <= cfg_y_step;
      auto_q  <= cfg_auto;
    end
  end

  assign addr = addr_q;

  AST_ELEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load && !last_x |=> addr_q == $past(addr_q) + $past(xstep_ext)); // R3
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load && last_x && !last_y |=> addr_q == $past(addr_q) + $past(ystep_ext)); // R4
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !load |=> $stable(addr_q)); // R3
  AST_WRAP_START: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load && last_x && last_y |=> addr_q == $past(start_q)); // R6
endmodule

// File: rtl/adgen_ctrl.sv
// Run/hold sequencing and sticky status flags.
module adgen_ctrl
  import adgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cfg_ok,
  input  logic accept,
  input  logic last_x,
  input  logic last_y,
  input  logic auto_q,
  input  logic done_clr,
  input  logic err_clr,
  output logic load,
  output logic run,
  output logic done,
  output logic err
);
  adgen_state_e state_q, state_d;
  logic done_q, done_d, err_q, err_d;
  logic fire_last, bad, done_set;

  always_comb begin
    fire_last = (state_q == ST_RUN) && accept && last_x && last_y;
    load      = 1'b0;
    bad       = 1'b0;
    state_d   = state_q;
    if (!enable) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cfg_ok) begin
            load    = 1'b1;
            state_d = ST_RUN;
          end else begin
            bad     = 1'b1;
            state_d = ST_HOLD;
          end
        end
        ST_RUN:  if (fire_last && !auto_q) state_d = ST_HOLD;
        ST_HOLD: state_d = ST_HOLD;
        default: state_d = ST_IDLE;
      endcase
    end
    done_set = enable && fire_last && !auto_q;
    done_d   = done_set | (done_q & ~done_clr);
    err_d    = bad | (err_q & ~err_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign run  = (state_q == ST_RUN);
  assign done = done_q;
  assign err  = err_q;

  AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    enable && fire_last && !auto_q |=> !run && done); // R5
  AST_AUTO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    enable && fire_last && auto_q |=> run); // R6
  AST_STICKY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_clr |=> done); // R7
  AST_BAD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !run && !cfg_ok && state_q == ST_IDLE |=> err && !run); // R9
  AST_DISABLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !run); // R11
endmodule

// File: rtl/adgen_2d.sv
module adgen_2d
  import adgen_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CW        = 16,
  parameter int SW        = 16,
  parameter int POSW      = 10,
  parameter int FRAME_W   = 480,
  parameter int PIX_BYTES = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            cfg_auto,
  input  logic            cfg_wide,
  input  logic            cfg_origin,
  input  logic [AW-1:0]   cfg_base,
  input  logic [POSW-1:0] cfg_col,
  input  logic [POSW-1:0] cfg_row,
  input  logic [CW-1:0]   cfg_x_count,
  input  logic [SW-1:0]   cfg_x_step,
  input  logic [CW-1:0]   cfg_y_count,
  input  logic [SW-1:0]   cfg_y_step,
  input  logic            accept,
  input  logic            done_clr,
  input  logic            err_clr,
  output logic [AW-1:0]   addr,
  output logic            valid,
  output logic            row_end,
  output logic            xfer_end,
  output logic            run,
  output logic            done,
  output logic            err
);
  logic [AW-1:0] start_addr;
  logic          cfg_ok, load, adv, last_x, last_y, auto_q, run_i;

  adgen_origin #(
    .AW(AW), .CW(CW), .POSW(POSW), .FRAME_W(FRAME_W), .PIX_BYTES(PIX_BYTES)
  ) u_origin (
    .cfg_origin (cfg_origin),
    .cfg_wide   (cfg_wide),
    .cfg_base   (cfg_base),
    .cfg_col    (cfg_col),
    .cfg_row    (cfg_row),
    .cfg_x_count(cfg_x_count),
    .cfg_y_count(cfg_y_count),
    .start_addr (start_addr),
    .cfg_ok     (cfg_ok)
  );

  adgen_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .cfg_ok  (cfg_ok),
    .accept  (accept),
    .last_x  (last_x),
    .last_y  (last_y),
    .auto_q  (auto_q),
    .done_clr(done_clr),
    .err_clr (err_clr),
    .load    (load),
    .run     (run_i),
    .done    (done),
    .err     (err)
  );

  assign adv = run_i & accept;

  adgen_walk #(.AW(AW), .CW(CW), .SW(SW)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .adv        (adv),
    .cfg_auto   (cfg_auto),
    .start_addr (start_addr),
    .cfg_x_count(cfg_x_count),
    .cfg_x_step (cfg_x_step),
    .cfg_y_count(cfg_y_count),
    .cfg_y_step (cfg_y_step),
    .addr       (addr),
    .last_x     (last_x),
    .last_y     (last_y),
    .auto_q     (auto_q)
  );

  assign run      = run_i;
  assign valid    = run_i;
  assign row_end  = run_i & last_x;
  assign xfer_end = run_i & last_x & last_y;

  AST_END_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> row_end); // R12
  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid && addr == $past(start_addr)); // R2
endmodule

// File: tb/sim_adgen_2d.sv
`timescale 1ns/1ps
module sim_adgen_2d;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, cfg_auto, cfg_wide, cfg_origin, accept, done_clr, err_clr;
  logic [31:0] cfg_base;
  logic [9:0]  cfg_col, cfg_row;
  logic [15:0] cfg_x_count, cfg_x_step, cfg_y_count, cfg_y_step;
  logic [31:0] addr;
  logic        valid, row_end, xfer_end, run, done, err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adgen_2d u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_auto(cfg_auto),
    .cfg_wide(cfg_wide), .cfg_origin(cfg_origin), .cfg_base(cfg_base),
    .cfg_col(cfg_col), .cfg_row(cfg_row), .cfg_x_count(cfg_x_count),
    .cfg_x_step(cfg_x_step), .cfg_y_count(cfg_y_count), .cfg_y_step(cfg_y_step),
    .accept(accept), .done_clr(done_clr), .err_clr(err_clr), .addr(addr),
    .valid(valid), .row_end(row_end), .xfer_end(xfer_end), .run(run),
    .done(done), .err(err)
  );

  // start, x count, x step, y count, y step, wide, expected last address
  localparam int NV = 4;
  localparam int VEC [NV][7] = '{
    '{32'h100,  4,  2, 3,    2, 0, 32'h116},
    '{32'h2000, 6,  2, 2, 1430, 0, 32'h25AA},
    '{32'h4000, 3,  4, 2,    4, 1, 32'h4014},
    '{32'h1000, 2, -2, 2,   -2, 0, 32'h0FFA}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic setup(input int base, input int xc, input int xs, input int yc,
                       input int ys, input bit wide, input bit autob);
    cfg_base    = 32'(base);
    cfg_x_count = 16'(xc);
    cfg_x_step  = 16'(xs);
    cfg_y_count = 16'(yc);
    cfg_y_step  = 16'(ys);
    cfg_wide    = wide;
    cfg_auto    = autob;
  endtask

  task automatic stop_all();
    enable = 1'b0; accept = 1'b0; done_clr = 1'b1; err_clr = 1'b1;
    tick();
    done_clr = 1'b0; err_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; accept = 1'b0; done_clr = 1'b0; err_clr = 1'b0;
    cfg_origin = 1'b0; cfg_col = '0; cfg_row = '0;
    setup(0, 1, 2, 1, 2, 0, 0);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 valid", 32'(valid), 0);
    chk("R1 run", 32'(run), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 addr", addr, 0);
    chk("R1 flags", {30'd0, row_end, xfer_end}, 0);

    // Vector table: full transfers with accept held high
    for (int v = 0; v < NV; v++) begin
      logic [31:0] last_seen;
      setup(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5][0], 0);
      enable = 1'b1; accept = 1'b1;
      tick();
      last_seen = '0;
      for (int r = 0; r < VEC[v][3]; r++) begin
        for (int c = 0; c < VEC[v][1]; c++) begin
          int e;
          e = VEC[v][0] + r * ((VEC[v][1] - 1) * VEC[v][2] + VEC[v][4]) + c * VEC[v][2];
          if (r == 0 && c == 0) chk("R2 start addr", addr, 32'(e));
          else if (c == 0)      chk("R4 row step addr", addr, 32'(e));
          else                  chk("R3 elem step addr", addr, 32'(e));
          chk("R4 row_end", 32'(row_end), 32'(c == VEC[v][1] - 1));
          chk("R12 xfer_end", 32'(xfer_end),
              32'(c == VEC[v][1] - 1 && r == VEC[v][3] - 1));
          last_seen = addr;
          tick();
        end
      end
      chk("R4 last addr", last_seen, 32'(VEC[v][6]));
      chk("R5 valid after end", 32'(valid), 0);
      chk("R5 done after end", 32'(done), 1);
      tick();
      chk("R5 stays idle while enabled", 32'(valid), 0);
      stop_all();
      chk("R7 done cleared", 32'(done), 0);
    end

    // R3 hold without accept, then R11 disable mid-transfer
    setup(32'h100, 4, 2, 3, 2, 0, 0);
    enable = 1'b1; accept = 1'b0;
    tick(); tick(); tick();
    chk("R3 hold addr", addr, 32'h100);
    accept = 1'b1; tick(); accept = 1'b0;
    chk("R3 single step", addr, 32'h102);
    enable = 1'b0; tick();
    chk("R11 run after disable", 32'(run), 0);
    chk("R11 valid after disable", 32'(valid), 0);
    chk("R11 done not set", 32'(done), 0);

    // R8 config change during run is ignored
    setup(32'h200, 3, 2, 2, 10, 0, 0);
    enable = 1'b1; tick();
    setup(32'h900, 3, 8, 2, 8, 0, 0);
    accept = 1'b1; tick();
    chk("R8 old step kept", addr, 32'h202);
    tick();
    chk("R8 old step kept 2", addr, 32'h204);
    tick();
    chk("R8 old row step kept", addr, 32'h20E);
    accept = 1'b0; enable = 1'b0; tick();
    enable = 1'b1; tick();
    chk("R8 new base after restart", addr, 32'h900);
    stop_all();

    // R6 autobuffer wrap
    setup(32'h300, 2, 4, 2, 4, 1, 1);
    enable = 1'b1; accept = 1'b1; tick();
    for (int i = 0; i < 4; i++) begin
      chk("R6 auto addr", addr, 32'h300 + 32'(4 * i));
      tick();
    end
    chk("R6 wrap to start", addr, 32'h300);
    chk("R6 still running", 32'(run), 1);
    chk("R6 no done", 32'(done), 0);
    stop_all();

    // R9 illegal configurations
    setup(32'h100, 0, 2, 1, 2, 0, 0);
    enable = 1'b1; tick();
    chk("R9 zero count err", 32'(err), 1);
    chk("R9 zero count no run", 32'(run), 0);
    enable = 1'b0; err_clr = 1'b1; tick(); err_clr = 1'b0;
    chk("R7 err cleared", 32'(err), 0);
    setup(32'h302, 2, 4, 1, 4, 1, 0);
    enable = 1'b1; tick();
    chk("R9 misaligned 32-bit err", 32'(err), 1);
    chk("R9 misaligned no valid", 32'(valid), 0);
    stop_all();
    setup(32'h302, 2, 2, 1, 2, 0, 0);
    enable = 1'b1; tick();
    chk("R9 16-bit aligned runs", 32'(run), 1);
    chk("R9 16-bit aligned no err", 32'(err), 0);
    stop_all();

    // R7 sticky done and R5 re-enable
    setup(32'h400, 1, 2, 1, 2, 0, 0);
    enable = 1'b1; accept = 1'b1; tick();
    chk("R2 one-element start", addr, 32'h400);
    tick(); accept = 1'b0;
    tick(); tick();
    chk("R7 done sticky while enabled", 32'(done), 1);
    chk("R5 no restart while enabled", 32'(valid), 0);
    enable = 1'b0; tick();
    chk("R7 done sticky after disable", 32'(done), 1);
    enable = 1'b1; tick();
    chk("R5 restart after re-enable", 32'(valid), 1);
    chk("R7 done still set", 32'(done), 1);
    done_clr = 1'b1; tick(); done_clr = 1'b0;
    chk("R7 done clear pulse", 32'(done), 0);
    stop_all();

    // R10 placement mode: column 5 rounds to 4, row 3
    setup(32'h10000, 6, 2, 2, 2, 0, 0);
    cfg_origin = 1'b1; cfg_col = 10'd5; cfg_row = 10'd3;
    enable = 1'b1; tick();
    chk("R10 placed start", addr, 32'h110EC);
    cfg_origin = 1'b0;
    stop_all();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule